// File: doc/BRIEF.md
# Extended Private Interrupt Active-State Clear Bank

This block keeps the active flag of each extended private peripheral interrupt served by one core's redistributor and gives software a way to drop that flag. Hardware raises a flag with a one-cycle activate pulse on the interrupt's line. Software reads the flags back through a small register port, and removes them by writing ones (write-one-to-clear). The bank covers interrupt numbers 1056 through 1119. These are held in two 32-bit words that sit at byte offsets 0x384 and 0x388 of the redistributor's SGI frame.

Every bit is filtered per access before software can see or change it. A bit for an interrupt that is not built reads as zero and cannot be written. The same holds for a bit whose security state has affinity routing turned off. A bit belonging to the secure group is hidden in the same way from non-secure accesses, unless the global security-disable flag is set. The true flags are also driven out on their own lines, together with an active-and-pending view that combines them with the pending inputs.

Top module: `pirq_active_clr`

## Requirements
- R1: While reset is asserted and right after it, every active flag is 0 and `rd_data` is 0.
- R2: A 1 on `act_set[i]` for a built interrupt makes `active_out[i]` 1 from the next cycle on. `act_pend_out[i]` equals `active_out[i] & pend_in[i]` in every cycle.
- R3: Interrupt m (1056..1119) lives in word n = (m-1024) DIV 32 at bit (m-1024) MOD 32, at byte offset 0x380 + 4*n. A read of such an offset returns the filtered flags of that word in `rd_data` one cycle after `reg_ren`. A read sees the flags as they were before any write in the same cycle.
- R4: Writing 1 to a visible bit clears an active flag on the next cycle. Writing 1 to an inactive flag changes nothing. Writing 0 never changes a flag.
- R5: If `act_set[i]` and a visible software clear of bit i arrive in the same cycle, the clear wins and the flag is 0 on the next cycle.
- R6: When `reg_nonsec`=1 and `sec_disable`=0, bits whose `irq_nsgroup` bit is 0 (secure group) read as 0 and ignore writes.
- R7: Secure accesses (`reg_nonsec`=0), and any access with `sec_disable`=1, see and clear bits of both groups.
- R8: Bits whose `IMPL_MASK` bit is 0 read as 0, ignore writes, and never become active.
- R9: A bit reads as 0 and ignores writes when routing is off for its group's state. The secure group (`irq_nsgroup`=0) is gated by `route_sec_en`, and the non-secure group (`irq_nsgroup`=1) by `route_nsec_en`.
- R10: Reads of any other offset (including 0x380, 0x38C and unaligned addresses) return 0, and writes to them change nothing. In a cycle after no read, `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Byte offset within the SGI frame |
| reg_wdata | input | 32 | Write data, 1 = clear |
| reg_wen | input | 1 | Write strobe |
| reg_ren | input | 1 | Read strobe |
| reg_nonsec | input | 1 | 1 = non-secure access |
| sec_disable | input | 1 | Global security-disable flag |
| route_sec_en | input | 1 | Affinity routing enabled for the secure state |
| route_nsec_en | input | 1 | Affinity routing enabled for the non-secure state |
| irq_nsgroup | input | NUM_REGS*32 | Per-interrupt group, 1 = non-secure |
| act_set | input | NUM_REGS*32 | Per-interrupt activate pulse |
| pend_in | input | NUM_REGS*32 | Per-interrupt pending status |
| rd_data | output | 32 | Read data, one cycle after `reg_ren` |
| active_out | output | NUM_REGS*32 | Active flags |
| act_pend_out | output | NUM_REGS*32 | Active-and-pending flags |

## Verification
A flag that is lost, stuck or cleared through a filter shows on `active_out` one cycle after the event that caused it. It stays visible there until hardware sets the flag again or software clears it. A wrong filter or word select shows in `rd_data` one cycle after the read. A clear that escapes the filter shows later, as a flag that drops out of `active_out`. The bench keeps a bit-true model of the flags and compares both views every cycle. This catches a divergence within one cycle of the stimulus that causes it.

// File: rtl/pirq_active_clr_pkg.sv
package pirq_active_clr_pkg;

  localparam int unsigned WORD_W      = 32;
  localparam int unsigned EXT_BASE_ID = 1024;

  // access attributes carried together through the bank
  typedef struct packed {
    logic rd;
    logic wr;
    logic nonsec;
  } acc_t;

  // word index holding interrupt id
  function automatic int unsigned word_of_id(int unsigned id);
    return (id - EXT_BASE_ID) / WORD_W;
  endfunction

  // bit position of interrupt id inside its word
  function automatic int unsigned bit_of_id(int unsigned id);
    return (id - EXT_BASE_ID) % WORD_W;
  endfunction

  // byte offset of word n in the frame
  function automatic int unsigned offset_of_word(int unsigned n, int unsigned frame_base);
    return frame_base + 4 * n;
  endfunction

  // whether one bit may be seen and cleared by the current access
  function automatic logic bit_visible(logic impl, logic grp_ns, logic nonsec,
                                       logic sec_dis, logic route_s, logic route_ns);
    logic routed;
    logic sec_hidden;
    routed     = grp_ns ? route_ns : route_s;
    sec_hidden = nonsec & ~sec_dis & ~grp_ns;
    return impl & routed & ~sec_hidden;
  endfunction

endpackage

// File: rtl/pirq_aclr_decode.sv
module pirq_aclr_decode #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned NUM_REGS   = 2,
  parameter int unsigned FIRST_N    = 1,
  parameter int unsigned FRAME_BASE = 32'h380
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_REGS-1:0] sel,
  output logic                hit
);
  import pirq_active_clr_pkg::*;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_word
    localparam int unsigned OFS = offset_of_word(FIRST_N + k, FRAME_BASE);
    assign sel[k] = (addr == ADDR_W'(OFS));
  end

  assign hit = |sel;

endmodule

// File: rtl/pirq_aclr_view.sv
module pirq_aclr_view #(
  parameter int unsigned      N         = 64,
  parameter logic [N-1:0]     IMPL_MASK = '1
) (
  input  logic         nonsec,
  input  logic         sec_disable,
  input  logic         route_sec_en,
  input  logic         route_nsec_en,
  input  logic [N-1:0] grp_ns,
  output logic [N-1:0] vis,
  output logic [N-1:0] sec_hidden
);
  import pirq_active_clr_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign vis[i] = bit_visible(IMPL_MASK[i], grp_ns[i], nonsec, sec_disable,
                                route_sec_en, route_nsec_en);
    assign sec_hidden[i] = nonsec & ~sec_disable & ~grp_ns[i];
  end

endmodule

// File: rtl/pirq_aclr_state.sv
module pirq_aclr_state #(
  parameter int unsigned  N         = 64,
  parameter logic [N-1:0] IMPL_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr_ev,
  output logic [N-1:0] active_q
);

  logic [N-1:0] set_eff;   // activations that will land
  logic [N-1:0] active_d;

  assign set_eff  = set_ev & ~clr_ev & IMPL_MASK;
  assign active_d = (active_q | set_eff) & ~clr_ev & IMPL_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) active_q <= '0;
    else        active_q <= active_d;
  end

  // R4 and R5: a clear always leaves the bit inactive
  a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_ev) |=> ((active_q & $past(clr_ev)) == '0));

  // R4: no flag drops without a clear
  a_r4_no_spurious_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (|active_q) |=> ((($past(active_q) & ~active_q) & ~$past(clr_ev)) == '0));

  // R2: an uncontested activation of a built bit lands
  a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_eff) |=> ((active_q & $past(set_eff)) == $past(set_eff)));

  // R8: unbuilt bits never turn active
  a_r8_unimpl_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_ev & ~IMPL_MASK)) |=> ((active_q & ~IMPL_MASK) == '0));

endmodule

// File: rtl/pirq_aclr_readback.sv
module pirq_aclr_readback #(
  parameter int unsigned NUM_REGS = 2,
  parameter int unsigned W        = 32,
  localparam int unsigned N       = NUM_REGS * W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ren,
  input  logic                hit,
  input  logic [NUM_REGS-1:0] sel,
  input  logic [N-1:0]        active_q,
  input  logic [N-1:0]        vis,
  output logic [W-1:0]        rd_q
);

  logic [W-1:0] word_mux;
  logic [W-1:0] vis_mux;

  always_comb begin
    word_mux = '0;
    vis_mux  = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      word_mux |= active_q[k*W +: W] & vis[k*W +: W] & {W{sel[k]}};
      vis_mux  |= vis[k*W +: W] & {W{sel[k]}};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         rd_q <= '0;
    else if (ren & hit) rd_q <= word_mux;
    else                rd_q <= '0;
  end

  // R10: a miss or an idle cycle yields zero data
  a_r10_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(ren && hit) |=> (rd_q == '0));

  // R6, R8, R9: filtered bits never appear in read data
  a_r6_hidden_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ren && hit) |=> ((rd_q & ~$past(vis_mux)) == '0));

endmodule

// File: rtl/pirq_active_clr.sv
module pirq_active_clr #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned NUM_REGS   = 2,
  parameter int unsigned FIRST_N    = 1,
  parameter int unsigned FRAME_BASE = 32'h380,
  parameter logic [NUM_REGS*32-1:0] IMPL_MASK = '1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [31:0]              reg_wdata,
  input  logic                     reg_wen,
  input  logic                     reg_ren,
  input  logic                     reg_nonsec,
  input  logic                     sec_disable,
  input  logic                     route_sec_en,
  input  logic                     route_nsec_en,
  input  logic [NUM_REGS*32-1:0]   irq_nsgroup,
  input  logic [NUM_REGS*32-1:0]   act_set,
  input  logic [NUM_REGS*32-1:0]   pend_in,
  output logic [31:0]              rd_data,
  output logic [NUM_REGS*32-1:0]   active_out,
  output logic [NUM_REGS*32-1:0]   act_pend_out
);
  import pirq_active_clr_pkg::*;

  localparam int unsigned W = WORD_W;
  localparam int unsigned N = NUM_REGS * W;

  acc_t                acc;
  logic [NUM_REGS-1:0] sel;
  logic                hit;
  logic [N-1:0]        vis;
  logic [N-1:0]        sec_hidden;
  logic [N-1:0]        clr_ev;     // software clears, already filtered
  logic [N-1:0]        active_q;

  assign acc = '{rd: reg_ren, wr: reg_wen, nonsec: reg_nonsec};

  pirq_aclr_decode #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .FIRST_N(FIRST_N), .FRAME_BASE(FRAME_BASE)
  ) u_decode (
    .addr(reg_addr), .sel(sel), .hit(hit)
  );

  pirq_aclr_view #(.N(N), .IMPL_MASK(IMPL_MASK)) u_view (
    .nonsec(acc.nonsec), .sec_disable(sec_disable),
    .route_sec_en(route_sec_en), .route_nsec_en(route_nsec_en),
    .grp_ns(irq_nsgroup), .vis(vis), .sec_hidden(sec_hidden)
  );

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_clr
    assign clr_ev[k*W +: W] = {W{acc.wr & sel[k]}} & reg_wdata & vis[k*W +: W];
  end

  pirq_aclr_state #(.N(N), .IMPL_MASK(IMPL_MASK)) u_state (
    .clk(clk), .rst_n(rst_n), .set_ev(act_set), .clr_ev(clr_ev), .active_q(active_q)
  );

  pirq_aclr_readback #(.NUM_REGS(NUM_REGS), .W(W)) u_read (
    .clk(clk), .rst_n(rst_n), .ren(acc.rd), .hit(hit), .sel(sel),
    .active_q(active_q), .vis(vis), .rd_q(rd_data)
  );

  assign active_out   = active_q;
  assign act_pend_out = active_q & pend_in;

  // R6: a non-secure clear aimed at a secure-group bit leaves it unchanged
  a_r6_secure_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.wr && hit && |(active_q & sec_hidden)) |=>
      ((($past(active_q) & $past(sec_hidden)) & ~active_q) == '0));

  // R10: writes that miss every word never clear a flag
  a_r10_miss_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.wr && !hit) |=> ((($past(active_q)) & ~active_q) == '0));

endmodule

// File: tb/pirq_active_clr_tb.sv
`timescale 1ns/1ps
module pirq_active_clr_tb;

  localparam int unsigned NR = 2;
  localparam int unsigned N  = NR * 32;
  localparam logic [N-1:0] IMPL = 64'h0FFF_FFFF_FFFF_FFFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [15:0]   addr = '0;
  logic [31:0]   wdata = '0;
  logic          wen = 1'b0, ren = 1'b0, ns = 1'b0, sd = 1'b0;
  logic          rs = 1'b1, rns = 1'b1;
  logic [N-1:0]  grp = '1, set = '0, pend = '0;
  logic [31:0]   rd_data;
  logic [N-1:0]  active_out, act_pend_out;

  logic [N-1:0]  model = '0;
  int            checks = 0, errors = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  pirq_active_clr #(.IMPL_MASK(IMPL)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wdata(wdata),
    .reg_wen(wen), .reg_ren(ren), .reg_nonsec(ns), .sec_disable(sd),
    .route_sec_en(rs), .route_nsec_en(rns), .irq_nsgroup(grp),
    .act_set(set), .pend_in(pend), .rd_data(rd_data),
    .active_out(active_out), .act_pend_out(act_pend_out)
  );

  // word index for an address, -1 when no word lives there
  function automatic int word_at(logic [15:0] a);
    for (int id = 1056; id < 1120; id += 32) begin
      int n = (id - 1024) / 32;
      if (a == 16'(32'h380 + 4 * n)) return n - 1;
    end
    return -1;
  endfunction

  function automatic logic seen(int i);
    logic routed, hidden;
    if (!IMPL[i]) return 1'b0;
    routed = grp[i] ? rns : rs;
    hidden = ns && !sd && !grp[i];
    return routed && !hidden;
  endfunction

  task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // one cycle: inputs already driven at a falling edge
  task automatic tick(string tag);
    logic [31:0]  exp_rd = '0;
    logic [N-1:0] clr = '0;
    int k = word_at(addr);
    for (int i = 0; i < N; i++) begin
      if (k >= 0 && i / 32 == k && seen(i)) begin
        if (ren) exp_rd[i % 32] = model[i];
        if (wen && wdata[i % 32]) clr[i] = 1'b1;
      end
    end
    @(posedge clk);
    model = (model | (set & IMPL)) & ~clr;
    @(negedge clk);
    chk({tag, " rd_data"}, N'(rd_data), N'(exp_rd));
    chk({tag, " active"}, active_out, model);
    chk("R2 act_pend", act_pend_out, model & pend);
    wen = 1'b0; ren = 1'b0; set = '0;
  endtask

  task automatic rd(logic [15:0] a);
    addr = a; ren = 1'b1;
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    addr = a; wdata = d; wen = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 reset active", active_out, '0);
    chk("R1 reset rd", N'(rd_data), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", active_out, '0);

    // R2 and R8: activate a built bit in each word and an unbuilt one
    set = (64'd1 << 0) | (64'd1 << 59) | (64'd1 << 60);
    pend = 64'd1 << 59;
    tick("R2");
    chk("R2 set", active_out, (64'd1 << 0) | (64'd1 << 59));
    chk("R8 unbuilt stays off", active_out & ~IMPL, '0);
    chk("R2 act_pend", act_pend_out, 64'd1 << 59);

    // R3: interrupt 1115 -> word 2, bit 27
    rd(16'h388); tick("R3");
    chk("R3 word2", N'(rd_data), 64'h0800_0000);
    rd(16'h384); tick("R3");
    chk("R3 word1", N'(rd_data), 64'h1);

    // R10: other offsets
    rd(16'h380); tick("R10");
    chk("R10 miss read", N'(rd_data), '0);
    wr(16'h38C, '1); tick("R10");
    wr(16'h386, '1); tick("R10");
    chk("R10 miss write", active_out, (64'd1 << 0) | (64'd1 << 59));

    // R4: zeros, inactive bit, active bit
    wr(16'h384, 32'h0); tick("R4");
    wr(16'h384, 32'h20); tick("R4");
    chk("R4 no effect", active_out, (64'd1 << 0) | (64'd1 << 59));
    wr(16'h384, 32'h1); tick("R4");
    chk("R4 cleared", active_out, 64'd1 << 59);

    // R5: set and clear in the same cycle
    set = 64'd1 << 3; wr(16'h384, 32'h8); tick("R5");
    chk("R5 clear wins", active_out & (64'd1 << 3), '0);

    // R6 / R7: secure-group bit 10
    grp = ~(64'd1 << 10);
    set = 64'd1 << 10; tick("R6");
    ns = 1'b1; sd = 1'b0;
    rd(16'h384); tick("R6");
    chk("R6 hidden read", N'(rd_data) & (64'd1 << 10), '0);
    wr(16'h384, 32'h400); tick("R6");
    chk("R6 write ignored", active_out & (64'd1 << 10), 64'd1 << 10);
    sd = 1'b1; rd(16'h384); tick("R7");
    chk("R7 sd visible", N'(rd_data) & (64'd1 << 10), 64'd1 << 10);
    sd = 1'b0; ns = 1'b0; wr(16'h384, 32'h400); tick("R7");
    chk("R7 secure clears", active_out & (64'd1 << 10), '0);

    // R9: routing off for the non-secure state hides word-2 bit 59
    rns = 1'b0; rd(16'h388); tick("R9");
    chk("R9 hidden read", N'(rd_data), '0);
    wr(16'h388, '1); tick("R9");
    chk("R9 write ignored", active_out & (64'd1 << 59), 64'd1 << 59);
    rns = 1'b1;

    // constrained random phase checked against the model
    for (int c = 0; c < 3000; c++) begin
      int pick = $urandom_range(0, 5);
      logic [15:0] a;
      case (pick)
        0, 1:    a = 16'h384;
        2, 3:    a = 16'h388;
        4:       a = 16'h380;
        default: a = 16'(16'h38C - 16'($urandom_range(0, 1) * 10));
      endcase
      set  = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      pend = {$urandom, $urandom};
      ns   = 1'($urandom);
      if (c % 50 == 0) begin
        sd  = 1'($urandom);
        rs  = ($urandom_range(0, 7) != 0);
        rns = ($urandom_range(0, 7) != 0);
        grp = {$urandom, $urandom};
      end
      addr  = a;
      wdata = $urandom | $urandom;
      wen   = 1'($urandom);
      ren   = 1'($urandom);
      tick("R3 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule